// File: doc/BRIEF.md
# Multi-channel interprocessor mailbox controller

The block is a memory-mapped mailbox. A local processor uses it to post eight-word messages to remote processors and to learn when each message has been taken. It holds a parameterised set of channels, 32 by default. Each channel has an owner vector, a destination vector, an interrupt mask, a pending-interrupt register, a mode/status register, a send trigger and an eight-word message buffer. The block drives one interrupt line per vector toward the processors.

A processor first unlocks the block by writing a key to a global lock register. It then claims an idle channel by writing its own one-hot vector to the channel's owner register, and reads that register back to confirm the claim. Next it selects a destination, fills the message buffer and writes its vector to the send register. The channel goes busy and raises the destination's interrupt line unless that line is masked.

The transfer ends in one of two ways. In automatic-acknowledge mode, the channel returns to idle and flags the acknowledge once the receiver has cleared every pending destination bit. In manual mode, the receiver acknowledges by writing the acknowledge bit of the mode register.

Top module: `mbox_ctrl`

## Requirements
- R1: After a synchronous active-low reset the block is locked, and the lock register reads 1. Every channel is idle with no acknowledge, so its mode register reads 0x10. Every mask is all ones. Owner, destination, pending and data registers read 0, and `irq_o` is 0.
- R2: The lock register is at byte address 0xA00. Writing 0x1ACCE551 there unlocks the block, and the register then reads 0. Writing any other value locks the block, and the register then reads 1. Writes to the lock register are accepted whether the block is locked or not.
- R3: While the block is locked, every write to a channel register is ignored.
- R4: Channel c occupies byte addresses c*0x40 to c*0x40+0x3C. Word offsets within a channel are: owner 0x00, destination 0x04, destination clear 0x08, pending 0x0C, mode 0x10, mask 0x14, interrupt clear 0x18, send 0x1C. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`. The destination clear, interrupt clear and send registers read as 0.
- R5: The mode register reads as follows: bit 4 is 1 when the channel is idle, bit 7 is 1 when the last transfer was acknowledged, and bit 0 is the automatic-acknowledge setting. A channel never shows busy and acknowledged at the same time.
- R6: A write to the owner register is stored only while the channel is idle. A write while the channel is busy leaves the stored value unchanged. The owner register reads back the stored value.
- R7: A write to the send register starts a transfer only if three conditions hold: the channel is idle, the owner register is nonzero, and the written value equals the owner register. A transfer start makes the channel busy, clears the acknowledge bit and loads the pending register with the destination register. Any other write to the send register has no effect.
- R8: `irq_o[v]` is the OR, over all channels, of pending bit v ANDed with the inverse of mask bit v. A mask bit of 1 suppresses that line. The output follows register changes at the same clock edge. A line is raised only while some channel is busy.
- R9: A write to the destination clear register clears the written bits in both the destination and pending registers. If the channel is busy, is in automatic mode and has no pending bit left after the clear, it becomes idle with the acknowledge bit set.
- R10: A write to the mode register sets the automatic bit from bit 0 of the written value. If the channel is busy and bit 7 of the written value is 1, the channel also becomes idle, sets the acknowledge bit and clears its pending register.
- R11: A write to the interrupt clear register clears the written pending bits and does not end the transfer.
- R12: A read of any address outside the channel area and outside the lock register returns 0.
- R13: Offsets 0x20 to 0x3C hold eight 32-bit message words, which can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 32 | Interrupt line per vector |

## Verification
Every write takes effect at the clock edge that samples `bus_wr`. Status, pending bits and `irq_o` therefore change at that same edge. Read data is registered and is due one edge after `bus_rd`. The bench drives the bus on falling edges, updates its reference model just after the rising edge that takes a write, and reads results after that rising edge. It compares `irq_o` against the model on every falling edge, so an interrupt that arrives a cycle early or late is caught.

// File: rtl/mbox_pkg.sv
// Shared constants and register offsets for the mailbox controller.
// Assumes a 32-bit data bus and word-aligned channel register slots.
package mbox_pkg;
    localparam int WORD_W    = 32;
    localparam int MSG_WORDS = 8;
    localparam int CHAN_SPAN_BITS = 6;          // 0x40 bytes per channel
    localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'h1ACCE551;
    localparam int MODE_AUTO_BIT = 0;
    localparam int MODE_IDLE_BIT = 4;
    localparam int MODE_ACK_BIT  = 7;

    typedef enum logic [3:0] {
        OFF_OWNER = 4'd0,
        OFF_DEST  = 4'd1,
        OFF_DCLR  = 4'd2,
        OFF_PEND  = 4'd3,
        OFF_MODE  = 4'd4,
        OFF_MASK  = 4'd5,
        OFF_ICLR  = 4'd6,
        OFF_SEND  = 4'd7
    } reg_off_e;
endpackage

// File: rtl/mbox_lock.sv
// Global write lock. Locked out of reset; the unlock key opens it and any
// other written value closes it again. Assumes the caller decodes the address.
module mbox_lock
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic              locked_o
);
    // Lock state register: set on reset, updated on every lock write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_o <= 1'b1;
        else if (wr_en)
            locked_o <= (wdata != UNLOCK_KEY);
    end
endmodule

// File: rtl/mbox_chan.sv
// One mailbox channel: owner, destination, mask, pending, mode/status and an
// eight-word message buffer. wr_en is already qualified by address and lock.
module mbox_chan
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        off,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata_o,
    output logic [WORD_W-1:0] irq_o,
    output logic              busy_o,
    output logic              ack_o
);
    localparam int DIDX_W = $clog2(MSG_WORDS);

    logic [WORD_W-1:0] owner_q, dest_q, mask_q, pend_q;
    logic [WORD_W-1:0] data_q [MSG_WORDS];
    logic              auto_q, busy_q, ack_q;
    logic [WORD_W-1:0] pend_after_clr;
    logic              send_ok;

    // Pending bits left after a clear, and whether a send write is valid.
    always_comb begin
        pend_after_clr = pend_q & ~wdata;
        send_ok = !busy_q && (owner_q != '0) && (wdata == owner_q);
    end

    // Register updates for all channel fields and the transfer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            dest_q  <= '0;
            mask_q  <= '1;
            pend_q  <= '0;
            auto_q  <= 1'b0;
            busy_q  <= 1'b0;
            ack_q   <= 1'b0;
            for (int i = 0; i < MSG_WORDS; i++) data_q[i] <= '0;
        end else if (wr_en) begin
            if (off[3]) begin
                data_q[off[DIDX_W-1:0]] <= wdata;
            end else begin
                case (reg_off_e'(off))
                    OFF_OWNER: if (!busy_q) owner_q <= wdata;
                    OFF_DEST:  dest_q <= wdata;
                    OFF_DCLR: begin
                        dest_q <= dest_q & ~wdata;
                        pend_q <= pend_after_clr;
                        if (busy_q && auto_q && pend_after_clr == '0) begin
                            busy_q <= 1'b0;
                            ack_q  <= 1'b1;
                        end
                    end
                    OFF_MODE: begin
                        auto_q <= wdata[MODE_AUTO_BIT];
                        if (busy_q && wdata[MODE_ACK_BIT]) begin
                            busy_q <= 1'b0;
                            ack_q  <= 1'b1;
                            pend_q <= '0;
                        end
                    end
                    OFF_MASK:  mask_q <= wdata;
                    OFF_ICLR:  pend_q <= pend_after_clr;
                    OFF_SEND: begin
                        if (send_ok) begin
                            busy_q <= 1'b1;
                            ack_q  <= 1'b0;
                            pend_q <= dest_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer for the addressed channel word.
    always_comb begin
        rdata_o = '0;
        if (off[3]) begin
            rdata_o = data_q[off[DIDX_W-1:0]];
        end else begin
            case (reg_off_e'(off))
                OFF_OWNER: rdata_o = owner_q;
                OFF_DEST:  rdata_o = dest_q;
                OFF_PEND:  rdata_o = pend_q;
                OFF_MASK:  rdata_o = mask_q;
                OFF_MODE: begin
                    rdata_o[MODE_AUTO_BIT] = auto_q;
                    rdata_o[MODE_IDLE_BIT] = !busy_q;
                    rdata_o[MODE_ACK_BIT]  = ack_q;
                end
                default:   rdata_o = '0;
            endcase
        end
    end

    // Unmasked pending interrupts and status toward the top level.
    assign irq_o  = pend_q & ~mask_q;
    assign busy_o = busy_q;
    assign ack_o  = ack_q;
endmodule

// File: rtl/mbox_irq_or.sv
// Merges the per-channel interrupt vectors into one set of lines by OR.
// Assumes every channel drives a vector of the same width.
module mbox_irq_or #(
    parameter int NUM_CHAN = 32,
    parameter int VEC_W    = 32
) (
    input  logic [VEC_W-1:0] irq_in [NUM_CHAN],
    output logic [VEC_W-1:0] irq_o
);
    // OR reduction across channels.
    always_comb begin
        irq_o = '0;
        for (int c = 0; c < NUM_CHAN; c++) irq_o = irq_o | irq_in[c];
    end
endmodule

// File: rtl/mbox_ctrl.sv
// Mailbox controller top: decodes the register bus, holds the global lock,
// instantiates the channels and merges their interrupts. Assumes the channel
// area starts at address 0 and that LOCK_ADDR lies outside it.
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int                NUM_CHAN  = 32,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] irq_o
);
    localparam int CHAN_BITS = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
    localparam logic [ADDR_W:0] CHAN_END = (ADDR_W+1)'(NUM_CHAN << CHAN_SPAN_BITS);

    logic                 locked;
    logic                 lock_hit, chan_hit;
    logic [CHAN_BITS-1:0] chan_sel;
    logic [3:0]           reg_off;
    logic [WORD_W-1:0]    chan_rdata [NUM_CHAN];
    logic [WORD_W-1:0]    chan_irq   [NUM_CHAN];
    logic [NUM_CHAN-1:0]  busy_vec, ack_vec;

    // Address decode into lock register, channel index and word offset.
    always_comb begin
        lock_hit = (bus_addr == LOCK_ADDR);
        chan_hit = ({1'b0, bus_addr} < CHAN_END);
        chan_sel = bus_addr[CHAN_SPAN_BITS +: CHAN_BITS];
        reg_off  = bus_addr[5:2];
    end

    mbox_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && lock_hit),
        .wdata    (bus_wdata),
        .locked_o (locked)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        mbox_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && chan_hit && !locked && chan_sel == CHAN_BITS'(c)),
            .off     (reg_off),
            .wdata   (bus_wdata),
            .rdata_o (chan_rdata[c]),
            .irq_o   (chan_irq[c]),
            .busy_o  (busy_vec[c]),
            .ack_o   (ack_vec[c])
        );
    end

    mbox_irq_or #(.NUM_CHAN(NUM_CHAN), .VEC_W(WORD_W)) u_irq_or (
        .irq_in (chan_irq),
        .irq_o  (irq_o)
    );

    // Registered read data: lock state, channel word, or zero when unmapped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd) begin
            if (lock_hit)
                bus_rdata <= {{(WORD_W-1){1'b0}}, locked};
            else if (chan_hit)
                bus_rdata <= chan_rdata[chan_sel];
            else
                bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/mbox_ctrl_chk.sv
// Property checker for mbox_ctrl, attached with bind. Decodes the bus itself
// and watches the lock state and per-channel status flags.
module mbox_ctrl_chk
    import mbox_pkg::*;
#(
    parameter int                NUM_CHAN  = 32,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [WORD_W-1:0] irq_o,
    input logic              locked,
    input logic [NUM_CHAN-1:0] busy_vec,
    input logic [NUM_CHAN-1:0] ack_vec
);
    localparam int CHK_END = NUM_CHAN * 64;
    logic at_lock, in_chan;
    assign at_lock = (bus_addr == LOCK_ADDR);
    assign in_chan = (int'(bus_addr) < CHK_END);

    // R2: the key opens the lock
    assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_lock && bus_wdata == UNLOCK_KEY) |=> !locked);
    // R2: any other value closes it
    assert_relock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_lock && bus_wdata != UNLOCK_KEY) |=> locked);
    // R3: while locked, channel status cannot move
    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(bus_wr && at_lock)) |=> ($stable(busy_vec) && $stable(ack_vec)));
    // R5: busy and acknowledged are exclusive
    assert_status_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy_vec & ack_vec) == '0));
    // R8: a raised line needs a busy channel
    assert_irq_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> (busy_vec != '0));
    // R12: unmapped reads return zero
    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !at_lock && !in_chan) |=> (bus_rdata == '0));
endmodule

bind mbox_ctrl mbox_ctrl_chk #(
    .NUM_CHAN (NUM_CHAN),
    .ADDR_W   (ADDR_W),
    .LOCK_ADDR(LOCK_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .locked   (locked),
    .busy_vec (busy_vec),
    .ack_vec  (ack_vec)
);

// File: tb/test_mbox_ctrl.sv
`timescale 1ns/1ps
module test_mbox_ctrl;
    localparam int NCH = 32;
    localparam logic [11:0] LOCKA = 12'hA00;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, irq_o;

    mbox_ctrl i_mbox_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model
    logic [31:0] m_owner [NCH];
    logic [31:0] m_dest  [NCH];
    logic [31:0] m_mask  [NCH];
    logic [31:0] m_pend  [NCH];
    logic [31:0] m_data  [NCH][8];
    bit          m_auto  [NCH];
    bit          m_busy  [NCH];
    bit          m_ack   [NCH];
    bit          m_locked;
    bit          model_on = 1'b0;
    bit          done = 1'b0;
    int          checks = 0, errors = 0;

    task automatic model_reset();
        m_locked = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            m_owner[c] = 0; m_dest[c] = 0; m_mask[c] = '1; m_pend[c] = 0;
            m_auto[c] = 0; m_busy[c] = 0; m_ack[c] = 0;
            for (int w = 0; w < 8; w++) m_data[c][w] = 0;
        end
    endtask

    function automatic logic [31:0] model_irq();
        logic [31:0] v = 0;
        for (int c = 0; c < NCH; c++) v |= m_pend[c] & ~m_mask[c];
        return v;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int c, o;
        if (a == LOCKA) begin
            m_locked = (d != KEY);
        end else if (a < NCH * 64 && !m_locked) begin
            c = a / 64; o = (a % 64) / 4;
            if (o >= 8) m_data[c][o - 8] = d;
            else case (o)
                0: if (!m_busy[c]) m_owner[c] = d;
                1: m_dest[c] = d;
                2: begin
                    m_dest[c] &= ~d; m_pend[c] &= ~d;
                    if (m_busy[c] && m_auto[c] && m_pend[c] == 0) begin
                        m_busy[c] = 0; m_ack[c] = 1;
                    end
                end
                4: begin
                    m_auto[c] = d[0];
                    if (m_busy[c] && d[7]) begin
                        m_busy[c] = 0; m_ack[c] = 1; m_pend[c] = 0;
                    end
                end
                5: m_mask[c] = d;
                6: m_pend[c] &= ~d;
                7: if (!m_busy[c] && m_owner[c] != 0 && d == m_owner[c]) begin
                    m_busy[c] = 1; m_ack[c] = 0; m_pend[c] = m_dest[c];
                end
                default: ;
            endcase
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int c, o;
        if (a == LOCKA) return m_locked ? 32'd1 : 32'd0;
        if (a >= NCH * 64) return 0;
        c = a / 64; o = (a % 64) / 4;
        if (o >= 8) return m_data[c][o - 8];
        case (o)
            0: return m_owner[c];
            1: return m_dest[c];
            3: return m_pend[c];
            4: return (32'(m_ack[c]) << 7) | (32'(!m_busy[c]) << 4) | 32'(m_auto[c]);
            5: return m_mask[c];
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison of the interrupt lines against the model (R8)
    always @(negedge clk) if (model_on && !done) chk("R8 irq_o vs model", irq_o, model_irq());

    function automatic logic [11:0] ca(input int c, input int off);
        return 12'(c * 64 + off);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    // Read and compare against the model
    task automatic rd_model(input logic [11:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        exp = model_read(a);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    // Read and compare against a value worked out from the requirements
    task automatic rd_exp(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic irq_exp(input logic [31:0] exp, input string tag);
        @(negedge clk);
        chk(tag, irq_o, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        model_on = 1'b1;

        // R1: reset state
        rd_exp(LOCKA, 32'd1, "R1 lock after reset");
        rd_exp(ca(0, 'h10), 32'h10, "R1 mode after reset");
        rd_exp(ca(7, 'h14), 32'hFFFF_FFFF, "R1 mask after reset");
        rd_exp(ca(7, 'h20), 32'h0, "R1 data after reset");
        irq_exp(32'h0, "R1 irq after reset");

        // R3: locked writes ignored
        wr(ca(3, 'h04), 32'h4);
        rd_exp(ca(3, 'h04), 32'h0, "R3 dest write while locked");

        // R2: wrong key keeps locked, right key unlocks
        wr(LOCKA, 32'h1234);
        rd_exp(LOCKA, 32'd1, "R2 wrong key");
        wr(LOCKA, KEY);
        rd_exp(LOCKA, 32'd0, "R2 unlock key");

        // R6 / R13: claim and fill channel 3
        wr(ca(3, 'h00), 32'h2);
        rd_exp(ca(3, 'h00), 32'h2, "R6 owner readback");
        for (int i = 0; i < 8; i++) wr(ca(3, 'h20 + 4 * i), 32'hA500_0000 + i);
        rd_exp(ca(3, 'h20), 32'hA500_0000, "R13 data word 0");
        rd_exp(ca(3, 'h3C), 32'hA500_0007, "R13 data word 7");
        for (int i = 0; i < 8; i++) rd_model(ca(3, 'h20 + 4 * i), "R13 data sweep");

        // R7 / R8 / R5: automatic channel 3 to vector 4
        wr(ca(3, 'h04), 32'h10);
        wr(ca(3, 'h14), ~32'h10);
        wr(ca(3, 'h10), 32'h1);
        rd_exp(ca(3, 'h10), 32'h11, "R5 idle with auto");
        wr(ca(3, 'h1C), 32'h4);
        rd_exp(ca(3, 'h10), 32'h11, "R7 send with wrong vector ignored");
        irq_exp(32'h0, "R7 no irq after bad send");
        wr(ca(3, 'h1C), 32'h2);
        irq_exp(32'h10, "R8 irq after send");
        rd_exp(ca(3, 'h10), 32'h01, "R7 busy after send");
        rd_exp(ca(3, 'h0C), 32'h10, "R7 pending loaded");
        rd_exp(ca(3, 'h1C), 32'h0, "R4 send reads zero");
        rd_exp(ca(3, 'h08), 32'h0, "R4 dest clear reads zero");

        // R6: owner write while busy ignored
        wr(ca(3, 'h00), 32'h8);
        rd_exp(ca(3, 'h00), 32'h2, "R6 owner held while busy");

        // R11: interrupt clear does not finish the transfer
        wr(ca(3, 'h18), 32'h10);
        irq_exp(32'h0, "R11 irq cleared");
        rd_exp(ca(3, 'h10), 32'h01, "R11 still busy");

        // R9: destination clear finishes in auto mode
        wr(ca(3, 'h08), 32'h10);
        rd_exp(ca(3, 'h10), 32'h91, "R9 auto ack");
        rd_exp(ca(3, 'h04), 32'h0, "R9 dest cleared");

        // R7: resend clears ack
        wr(ca(3, 'h04), 32'h10);
        wr(ca(3, 'h1C), 32'h2);
        rd_exp(ca(3, 'h10), 32'h01, "R7 resend clears ack");
        wr(ca(3, 'h08), 32'h10);

        // R10: manual mode on channel 31
        wr(ca(31, 'h00), 32'h1);
        wr(ca(31, 'h04), 32'h3);
        wr(ca(31, 'h14), 32'h0);
        wr(ca(31, 'h1C), 32'h1);
        irq_exp(32'h3, "R8 two lines from one channel");
        wr(ca(31, 'h08), 32'h1);
        rd_exp(ca(31, 'h10), 32'h00, "R9 manual stays busy");
        rd_exp(ca(31, 'h0C), 32'h2, "R9 partial clear");
        wr(ca(31, 'h10), 32'h80);
        rd_exp(ca(31, 'h10), 32'h90, "R10 manual ack");
        rd_exp(ca(31, 'h0C), 32'h0, "R10 pending cleared");
        irq_exp(32'h0, "R10 irq dropped");

        // R9: auto mode needs every pending bit cleared
        wr(ca(5, 'h00), 32'h4);
        wr(ca(5, 'h04), 32'h3);
        wr(ca(5, 'h14), 32'h0);
        wr(ca(5, 'h10), 32'h1);
        wr(ca(5, 'h1C), 32'h4);
        wr(ca(5, 'h08), 32'h1);
        rd_exp(ca(5, 'h10), 32'h01, "R9 auto waits for last bit");
        wr(ca(5, 'h08), 32'h2);
        rd_exp(ca(5, 'h10), 32'h91, "R9 auto done after last bit");

        // R8: OR across channels and masking
        wr(ca(1, 'h00), 32'h1);
        wr(ca(1, 'h04), 32'h100);
        wr(ca(1, 'h14), 32'h0);
        wr(ca(1, 'h1C), 32'h1);
        wr(ca(2, 'h00), 32'h1);
        wr(ca(2, 'h04), 32'h200);
        wr(ca(2, 'h14), 32'h200);
        wr(ca(2, 'h1C), 32'h1);
        irq_exp(32'h100, "R8 masked line suppressed");
        wr(ca(2, 'h14), 32'h0);
        irq_exp(32'h300, "R8 OR of two channels");

        // R3: relock, then writes have no effect
        wr(LOCKA, 32'h0);
        rd_exp(LOCKA, 32'd1, "R2 relock");
        wr(ca(1, 'h18), 32'h100);
        wr(ca(2, 'h10), 32'h80);
        irq_exp(32'h300, "R3 locked clear ignored");
        rd_exp(ca(2, 'h10), 32'h00, "R3 locked ack ignored");

        // R12: unmapped addresses
        rd_exp(12'h800, 32'h0, "R12 above channels");
        rd_exp(12'h9FC, 32'h0, "R12 below lock");
        rd_exp(12'hA04, 32'h0, "R12 after lock");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule